// File: doc/BRIEF.md
# Write-Only Serial Configuration Target

This block is a receive-only target on a two-wire serial bus (I2C write transfers only). It loads a small bank of configuration registers from one fixed-format write. SCL and SDA come from the pads and are resampled into the system clock domain. The block answers only by pulling SDA low through an open-drain enable. The register bank is presented as a flat parallel vector, so downstream clock-control logic can decode its fields directly.

A transfer opens with START and the device address byte. Two framing bytes follow; they are acknowledged but their values are discarded. Every later byte lands in the next register in order, starting at register 0. There is no register pointer and no read path.

The bus has no stall mechanism, since clock stretching is not supported. The register outputs are therefore plain levels with no valid/ready handshake. A register takes its new value at the SCL falling edge that opens the acknowledge slot for that byte, and holds it until it is overwritten or reset.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset the seven registers hold, from register 0 to register 6: 0x00, 0x1B, 0x5F, 0x37, 0x00, 0x13, 0x00. These are output-enable bits at 1 and reserved bits at 0, with the frequency-source select (register 0 bit 3) at 0. `sda_pull_o` is 0 after reset.
- R2: The first byte after START must equal 0xD2 exactly (7-bit address 0x69 followed by write bit 0). Any other value, including 0xD3, gets no acknowledge on that byte or on any later byte of the transfer, and no register changes.
- R3: After a matching address, `sda_pull_o` is 1 throughout the high phase of the 9th SCL clock of every byte, and is 0 during the data bits. It is released at STOP.
- R4: The second and third bytes of a transfer are acknowledged, and their values reach no register.
- R5: The fourth byte goes into register 0, the fifth into register 1, and so on. A transfer that ends early leaves the remaining registers unchanged.
- R6: Bits are taken most significant first; the first data bit on the wire becomes bit 7 of the register.
- R7: Data bytes after the seventh are acknowledged and dropped. Indexing does not wrap back to register 0.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START discards any partly received byte and restarts address matching, with the byte position reset to the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the pad, asynchronous |
| sda_i | input | 1 | Serial data as seen on the bus, asynchronous |
| sda_pull_o | output | 1 | 1 enables the open-drain pull-down of SDA |
| cfg_o | output | 56 | Registers packed together, register k in bits [8k+7:8k] |

## Verification
The embedded assertions check the following on every cycle:
- the acknowledge pull-down only starts while the resampled SCL is low;
- the pull-down is dropped at STOP and only ever ends on an SCL fall or a bus condition;
- register writes never address past the last register;
- registers stay put when no write is strobed.

The bench scenarios are needed for the value-level behaviour: the address filter including the read-bit case, discarding of the framing bytes, positional storage and bit order, dropping of surplus bytes, and recovery after a repeated START that cuts a byte short.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int CFG_REGS = 7;
  localparam logic [7:0] DEV_ADDR_WR = 8'hD2;
  // register 6 in the top byte, register 0 in the bottom byte
  localparam logic [CFG_REGS*8-1:0] CFG_RESET = {8'h00, 8'h13, 8'h00, 8'h37, 8'h5F, 8'h1B, 8'h00};

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_cfg_pkg::*;
#(
  parameter int          NREGS      = CFG_REGS,
  parameter int          SKIP_BYTES = 2,
  parameter logic [7:0]  ADDR_BYTE  = DEV_ADDR_WR,
  localparam int         RIDX_W     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              ack_pull,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [7:0]        wr_data
);
  localparam int BYTE_LIMIT = 1 + SKIP_BYTES + NREGS;
  localparam int CNT_W      = $clog2(BYTE_LIMIT + 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(SKIP_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(SKIP_BYTES + NREGS);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(BYTE_LIMIT);

  rx_state_e        state;
  logic [7:0]       shreg;
  logic [3:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      ack_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= RX_BITS;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= RX_IDLE;
        ack_pull <= 1'b0;
      end else begin
        unique case (state)
          RX_BITS: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_bit};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (byte_cnt == '0 && shreg != ADDR_BYTE) begin
                state <= RX_SKIP;
              end else begin
                state    <= RX_ACK;
                ack_pull <= 1'b1;
                if (byte_cnt >= FIRST_DATA && byte_cnt <= LAST_DATA) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= RIDX_W'(byte_cnt - FIRST_DATA);
                  wr_data <= shreg;
                end
                if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              ack_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> !scl_lvl); // R3
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !ack_pull); // R3
  AST_ACK_ENDS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_pull) |-> $past(scl_fall || start_det || stop_det)); // R8
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREGS)); // R7
  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ack_pull); // R5
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int                    NREGS  = 7,
  parameter logic [NREGS*8-1:0]    RST_VAL = '0,
  localparam int                   RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RIDX_W-1:0]  wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NREGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_o[g*8 +: 8] <= RST_VAL[g*8 +: 8];
      else if (wr_en && wr_idx == RIDX_W'(g)) regs_o[g*8 +: 8] <= wr_data;
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R2
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int                   NREGS      = CFG_REGS,
  parameter int                   SKIP_BYTES = 2,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [7:0]           ADDR_BYTE  = DEV_ADDR_WR,
  parameter logic [NREGS*8-1:0]   RST_VAL    = CFG_RESET
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREGS*8-1:0] cfg_o
);
  localparam int RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [RIDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_wr_engine #(.NREGS(NREGS), .SKIP_BYTES(SKIP_BYTES), .ADDR_BYTE(ADDR_BYTE)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .sda_bit(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_reg_file #(.NREGS(NREGS), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_o(cfg_o)
  );
endmodule

// File: tb/i2c_cfg_target_tb.sv
module i2c_cfg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [55:0] cfg;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_r [7];
  logic [7:0] tx_buf [16];
  int tx_len;
  logic [15:0] acks;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic mid;
    send_bits(b, 8);
    chk(sda_pull == 1'b0, "R3 no pull during data bits", sda_pull, 0);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(1);
    acked = sda_pull; wait_q(Q/2);
    mid = sda_pull; wait_q(Q/2 - 1);
    if (acked) chk(mid == 1'b1, "R3 pull held through 9th clock", mid, 1);
    scl_m = 1'b0;
  endtask

  task automatic send_list(input int from);
    logic a;
    for (int i = from; i < tx_len; i++) begin
      send_byte(tx_buf[i], a);
      acks[i] = a;
    end
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < 7; k++)
      chk(cfg[k*8 +: 8] == exp_r[k], tag, cfg[k*8 +: 8], exp_r[k]);
  endtask

  task automatic t_reset();
    exp_r = '{8'h00, 8'h1B, 8'h5F, 8'h37, 8'h00, 8'h13, 8'h00};
    check_regs("R1 reset value");
    chk(sda_pull == 1'b0, "R1 no pull after reset", sda_pull, 0);
  endtask

  task automatic t_full_write();
    tx_buf[0] = 8'hD2; tx_buf[1] = 8'hAA; tx_buf[2] = 8'h55;
    tx_buf[3] = 8'h80; tx_buf[4] = 8'h01; tx_buf[5] = 8'hC3; tx_buf[6] = 8'h3C;
    tx_buf[7] = 8'hF0; tx_buf[8] = 8'h0F; tx_buf[9] = 8'h96;
    tx_len = 10; acks = '0;
    bus_start(); send_list(0); bus_stop(); wait_q(4);
    chk(acks[9:0] == 10'h3FF, "R3 every byte acked after match", acks[9:0], 10'h3FF);
    chk(acks[2:1] == 2'b11, "R4 framing bytes acked", acks[2:1], 2'b11);
    for (int k = 0; k < 7; k++) exp_r[k] = tx_buf[k+3];
    check_regs("R5 positional store");
    chk(cfg[7:0] == 8'h80, "R6 first wire bit is bit 7", cfg[7:0], 8'h80);
    chk(cfg[15:8] == 8'h01, "R6 last wire bit is bit 0", cfg[15:8], 8'h01);
    chk(sda_pull == 1'b0, "R3 released after stop", sda_pull, 0);
  endtask

  task automatic t_wrong_addr(input logic [7:0] addr);
    tx_buf[0] = addr; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    tx_buf[3] = 8'h11; tx_buf[4] = 8'h22;
    tx_len = 5; acks = '0;
    bus_start(); send_list(0); bus_stop(); wait_q(4);
    chk(acks[4:0] == 5'b0, "R2 no ack for foreign address", acks[4:0], 0);
    check_regs("R2 no update for foreign address");
  endtask

  task automatic t_partial();
    tx_buf[0] = 8'hD2; tx_buf[1] = 8'h00; tx_buf[2] = 8'h07;
    tx_buf[3] = 8'h5A; tx_buf[4] = 8'hA5;
    tx_len = 5; acks = '0;
    bus_start(); send_list(0); bus_stop(); wait_q(4);
    exp_r[0] = 8'h5A; exp_r[1] = 8'hA5;
    check_regs("R5 short transfer leaves upper registers");
  endtask

  task automatic t_overflow();
    tx_buf[0] = 8'hD2; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02;
    for (int k = 0; k < 9; k++) tx_buf[k+3] = 8'h40 + 8'(k);
    tx_len = 12; acks = '0;
    bus_start(); send_list(0); bus_stop(); wait_q(4);
    chk(acks[11:10] == 2'b11, "R7 surplus bytes acked", acks[11:10], 2'b11);
    for (int k = 0; k < 7; k++) exp_r[k] = 8'h40 + 8'(k);
    check_regs("R7 surplus dropped without wrap");
  endtask

  task automatic rep_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h3C, a);
    send_bits(8'hA0, 4);
    rep_start();
    tx_buf[0] = 8'hD2; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h77;
    tx_len = 4; acks = '0;
    send_list(0); bus_stop(); wait_q(4);
    chk(acks[3:0] == 4'hF, "R8 restart re-matches address", acks[3:0], 4'hF);
    exp_r[0] = 8'h77;
    check_regs("R8 byte position reset by repeated start");
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    rep_start();
    send_byte(8'hD3, a);
    chk(a == 1'b0, "R8 restart with read bit not acked", a, 0);
    send_byte(8'h99, a);
    chk(a == 1'b0, "R2 later byte after mismatch not acked", a, 0);
    bus_stop(); wait_q(4);
    check_regs("R8 no update after mismatched restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_q(5);
    rst_n = 1'b1;
    wait_q(5);
    t_reset();
    t_wrong_addr(8'hA4);
    t_full_write();
    t_wrong_addr(8'hD3);
    t_partial();
    t_overflow();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule